// File: doc/BRIEF.md
# Serial Flash Programming Slave

This block lets an external programmer load and inspect a 4K-byte on-chip code store over a three-wire serial link. It is active while `isp_active` is high. The programmer drives a shift clock and a data-in line, and it reads the reply on a data-out line. Both incoming lines are sampled in the system-clock domain. Every command is a 4-byte frame, with one exception. The two page commands stream 256 data bytes after their opcode byte and their address byte.

Memory writes and chip erase are self-timed. A busy timer counts system clocks. While it runs, the memory write port is closed to new writes. Read replies also change while it runs: during a write, a read of the last location written returns its data with bit 7 inverted. During an erase, every read returns 0x00. A programmer can therefore poll for completion instead of waiting a fixed time.

Top module: `isp_prog_slave`

## Requirements
- R1: Each command is four bytes, sent MSB first. Data in is taken on each detected rising edge of the shift clock, after a two-flop synchroniser. The data-out line changes only after a detected falling edge. A reply is sent MSB first during the byte that follows the byte which triggered it.
- R2: The enable command is 0xAC, 0x53, then any two bytes, and its fourth byte returns 0x69. Until this command has completed, every other command is ignored: reads return 0x00 and writes, erase and lock writes have no effect.
- R3: Byte read uses opcode 0x20 and byte write uses 0x40. Byte 2 holds address bits 11..8 in its low nibble, byte 3 holds address bits 7..0, and byte 4 carries the write data or returns the read data.
- R4: Chip erase is 0xAC, then a second byte of the form 100x_xxxx, then two bytes. It sets every location to 0xFF and clears all lock bits. The busy period lasts at least ERASE_CYCLES and at least one clock per location. During it every read, signature read and lock read returns 0x00.
- R5: A byte write starts a busy period of WR_CYCLES clocks. During it, a read of the address just written returns the data with bit 7 inverted, and other addresses return true data. After it ends, true data is returned.
- R6: A memory write or erase command that completes while the busy timer runs is dropped.
- R7: Page read (0x30) and page write (0x50) take an opcode byte and an address byte (bits 11..8 in the low nibble), then exactly 256 data bytes at offsets 0 to 255. The next byte is decoded as a new opcode. A page write starts the write busy period after its last byte, and the last written address is offset 0xFF.
- R8: Signature read uses opcode 0x28, with the address formed as for a byte read. Address 0x000 returns 0x1E, 0x100 returns 0x61, 0x200 returns 0x06, and any other address returns 0x00.
- R9: Lock write is 0xAC, then 1110_00mm. A value of mm=01 programs lock 1, mm=10 programs lock 2, mm=11 programs lock 3, and mm=00 changes nothing. Programmed bits stay set until an erase. Lock read (0x24) returns lock 1 at bit 2, lock 2 at bit 3 and lock 3 at bit 4, with 1 meaning programmed and all other bits 0.
- R10: Driving `isp_active` low at any point returns framing, the enable state and the busy timer to idle. Memory contents are kept, and the enable command must be sent again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| isp_active | input | 1 | High enables the programming slave; low holds it idle |
| sck | input | 1 | Serial shift clock from the programmer, asynchronous |
| mosi | input | 1 | Serial data in, asynchronous |
| miso | output | 1 | Serial data out |

## Verification
The checker watches the following on every cycle:
- the data-out line changes only after a detected falling edge;
- the enable state stays set once reached;
- byte framing advances only on a completed byte;
- a page always starts at offset 0;
- a byte write raises the busy timer;
- erase clears the lock bits and finishes its sweep within the busy period;
- lock bits drop only on an erase;
- read replies are zero during an erase.

The decoded values themselves can only be shown by the bench's scenarios. These include the enable echo, polling data with bit 7 inverted, writes dropped while busy, signature and lock encodings, page streaming followed by a new opcode, and a frame cut short by `isp_active` going low.

// File: rtl/isp_prog_slave.sv
module isp_prog_slave #(
  parameter int ADDR_W       = 12,
  parameter int WR_CYCLES    = 1500,
  parameter int ERASE_CYCLES = 4000
) (
  input  logic clk,
  input  logic isp_active,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  localparam int MEM_SIZE  = 1 << ADDR_W;
  localparam int ERASE_LEN = (ERASE_CYCLES > MEM_SIZE) ? ERASE_CYCLES : MEM_SIZE;
  localparam int BUSY_MAX  = (WR_CYCLES > ERASE_LEN) ? WR_CYCLES : ERASE_LEN;
  localparam int CNT_W     = $clog2(BUSY_MAX + 1);

  localparam logic [2:0] K_NONE = 3'd0, K_MEM = 3'd1, K_SIG = 3'd2,
                         K_LOCK = 3'd3, K_ECHO = 3'd4;

  logic [2:0] sck_s;
  logic [1:0] mosi_s;
  logic [2:0] bit_cnt;
  logic [1:0] byte_idx;
  logic [6:0] shift_in;
  logic [7:0] op, b1, b2;
  logic enabled, in_page, page_wr, load_pend, erase_run, erase_sweep;
  logic [7:0] page_off, sig_val, mem_q, out_sh, resp;
  logic [2:0] kind, lock, lock_bit;
  logic [ADDR_W-1:0] rd_addr, last_addr, erase_ptr;
  logic [CNT_W-1:0] busy_cnt;
  logic [7:0] mem [MEM_SIZE];

  always_ff @(posedge clk) begin
    sck_s  <= {sck_s[1:0], sck};
    mosi_s <= {mosi_s[0], mosi};
  end

  wire sck_rise  = sck_s[1] & ~sck_s[2];
  wire sck_fall  = ~sck_s[1] & sck_s[2];
  wire [7:0] byte_in = {shift_in, mosi_s[1]};
  wire byte_done = sck_rise && bit_cnt == 3'd7;
  wire busy      = busy_cnt != '0;

  wire is_en    = op == 8'hAC && b1 == 8'h53;
  wire is_erase = op == 8'hAC && b1[7:5] == 3'b100;
  wire is_lockw = op == 8'hAC && b1[7:2] == 6'b111000;

  wire final_byte = !in_page && byte_idx == 2'd3;
  wire [ADDR_W-1:0] byte_addr = ADDR_W'({b1, b2});
  wire [ADDR_W-1:0] page_addr = ADDR_W'({b1, page_off});
  wire [ADDR_W-1:0] page_next = ADDR_W'({b1, page_off + 8'd1});
  wire [ADDR_W-1:0] wr_addr   = in_page ? page_addr : byte_addr;

  wire wr_go    = isp_active && byte_done && enabled && !busy &&
                  (in_page ? page_wr : (final_byte && op == 8'h40));
  wire erase_go = isp_active && byte_done && enabled && !busy && final_byte && is_erase;
  wire lock_go  = isp_active && byte_done && enabled && final_byte && is_lockw;
  wire start_wr_timer = wr_go && (!in_page || page_off == 8'hFF);
  wire resp_is_read   = kind == K_MEM || kind == K_SIG || kind == K_LOCK;

  assign miso = out_sh[7];

  always_comb begin
    case (kind)
      K_MEM:   resp = (busy && !erase_run && rd_addr == last_addr) ? (mem_q ^ 8'h80) : mem_q;
      K_SIG:   resp = sig_val;
      K_LOCK:  resp = {3'b000, lock, 2'b00};
      K_ECHO:  resp = 8'h69;
      default: resp = 8'h00;
    endcase
    if (busy && erase_run && resp_is_read) resp = 8'h00;
  end

  always_comb begin
    case (b1[1:0])
      2'b01:   lock_bit = 3'b001;
      2'b10:   lock_bit = 3'b010;
      2'b11:   lock_bit = 3'b100;
      default: lock_bit = 3'b000;
    endcase
  end

  function automatic logic [7:0] sig_lookup(input logic [11:0] a);
    case (a)
      12'h000: return 8'h1E;
      12'h100: return 8'h61;
      12'h200: return 8'h06;
      default: return 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!isp_active) begin
      bit_cnt     <= '0;
      byte_idx    <= '0;
      enabled     <= 1'b0;
      in_page     <= 1'b0;
      page_wr     <= 1'b0;
      page_off    <= '0;
      kind        <= K_NONE;
      load_pend   <= 1'b0;
      out_sh      <= '0;
      busy_cnt    <= '0;
      erase_run   <= 1'b0;
      erase_sweep <= 1'b0;
      erase_ptr   <= '0;
    end else begin
      if (busy) busy_cnt <= busy_cnt - CNT_W'(1);
      if (start_wr_timer) begin
        busy_cnt  <= CNT_W'(WR_CYCLES);
        erase_run <= 1'b0;
        last_addr <= wr_addr;
      end
      if (erase_go) begin
        busy_cnt    <= CNT_W'(ERASE_LEN);
        erase_run   <= 1'b1;
        erase_sweep <= 1'b1;
        erase_ptr   <= '0;
      end else if (erase_sweep) begin
        erase_ptr <= erase_ptr + 1'b1;
        if (&erase_ptr) erase_sweep <= 1'b0;
      end

      if (sck_rise) begin
        shift_in <= {shift_in[5:0], mosi_s[1]};
        bit_cnt  <= bit_cnt + 3'd1;
      end

      if (byte_done) begin
        load_pend <= 1'b1;
        kind      <= K_NONE;
        if (in_page) begin
          if (page_off == 8'hFF) begin
            in_page <= 1'b0;
          end else begin
            page_off <= page_off + 8'd1;
            if (!page_wr) begin
              rd_addr <= page_next;
              kind    <= K_MEM;
            end
          end
        end else begin
          case (byte_idx)
            2'd0: begin
              op       <= byte_in;
              byte_idx <= 2'd1;
            end
            2'd1: begin
              b1 <= byte_in;
              if (enabled && (op == 8'h30 || op == 8'h50)) begin
                in_page  <= 1'b1;
                page_off <= '0;
                page_wr  <= op == 8'h50;
                byte_idx <= 2'd0;
                if (op == 8'h30) begin
                  rd_addr <= ADDR_W'({byte_in, 8'h00});
                  kind    <= K_MEM;
                end
              end else begin
                byte_idx <= 2'd2;
              end
            end
            2'd2: begin
              b2       <= byte_in;
              byte_idx <= 2'd3;
              if (is_en) kind <= K_ECHO;
              else if (enabled) begin
                case (op)
                  8'h20: begin
                    rd_addr <= ADDR_W'({b1, byte_in});
                    kind    <= K_MEM;
                  end
                  8'h28: begin
                    sig_val <= sig_lookup({b1[3:0], byte_in});
                    kind    <= K_SIG;
                  end
                  8'h24: kind <= K_LOCK;
                  default: kind <= K_NONE;
                endcase
              end
            end
            default: begin
              byte_idx <= 2'd0;
              if (is_en) enabled <= 1'b1;
            end
          endcase
        end
      end

      if (sck_fall) begin
        if (load_pend) begin
          out_sh    <= resp;
          load_pend <= 1'b0;
        end else begin
          out_sh <= {out_sh[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    mem_q <= mem[rd_addr];
    if (erase_sweep) mem[erase_ptr] <= 8'hFF;
    else if (wr_go) mem[wr_addr] <= byte_in;
    if (erase_go) lock <= 3'b000;
    else if (lock_go) lock <= lock | lock_bit;
  end
endmodule

// File: rtl/isp_prog_checker.sv
module isp_prog_checker (
  input logic       clk,
  input logic       isp_active,
  input logic       miso,
  input logic       sck_fall,
  input logic       byte_done,
  input logic [1:0] byte_idx,
  input logic       enabled,
  input logic       in_page,
  input logic [7:0] page_off,
  input logic       wr_go,
  input logic       erase_go,
  input logic       erase_sweep,
  input logic       erase_run,
  input logic       busy,
  input logic       load_pend,
  input logic       resp_is_read,
  input logic [2:0] lock
);
  logic armed;
  always_ff @(posedge clk) armed <= isp_active;

  assert_miso_on_fall_R1: assert property (@(posedge clk) disable iff (!isp_active || !armed)
    (miso != $past(miso)) |-> $past(sck_fall));

  assert_frame_hold_R1: assert property (@(posedge clk) disable iff (!isp_active || !armed)
    !byte_done |=> $stable(byte_idx));

  assert_enable_sticky_R2: assert property (@(posedge clk) disable iff (!isp_active || !armed)
    $past(enabled) |-> enabled);

  assert_erase_clears_lock_R4: assert property (@(posedge clk) disable iff (!isp_active)
    erase_go |=> lock == 3'b000);

  assert_sweep_in_busy_R4: assert property (@(posedge clk) disable iff (!isp_active)
    erase_sweep |-> busy);

  assert_erase_reads_zero_R4: assert property (@(posedge clk) disable iff (!isp_active)
    (busy && erase_run && sck_fall && load_pend && resp_is_read) |=> miso == 1'b0);

  assert_write_sets_busy_R6: assert property (@(posedge clk) disable iff (!isp_active)
    (wr_go && !in_page) |=> busy);

  assert_page_from_zero_R7: assert property (@(posedge clk) disable iff (!isp_active || !armed)
    $rose(in_page) |-> page_off == 8'h00);

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!isp_active || !armed)
    (|($past(lock) & ~lock)) |-> $past(erase_go));
endmodule

bind isp_prog_slave isp_prog_checker u_chk (
  .clk(clk), .isp_active(isp_active), .miso(miso), .sck_fall(sck_fall),
  .byte_done(byte_done), .byte_idx(byte_idx), .enabled(enabled),
  .in_page(in_page), .page_off(page_off), .wr_go(wr_go), .erase_go(erase_go),
  .erase_sweep(erase_sweep), .erase_run(erase_run), .busy(busy),
  .load_pend(load_pend), .resp_is_read(resp_is_read), .lock(lock)
);

// File: tb/isp_prog_slave_test.sv
module isp_prog_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 10;
  localparam int WR_CYC     = 1500;
  localparam int ER_CYC     = 4000;

  logic clk = 1'b0;
  logic isp_active = 1'b0;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] model [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  isp_prog_slave #(.ADDR_W(12), .WR_CYCLES(WR_CYC), .ERASE_CYCLES(ER_CYC)) uut (
    .clk(clk), .isp_active(isp_active), .sck(sck), .mosi(mosi), .miso(miso));

  function automatic logic [7:0] mexp(int a);
    return model.exists(a) ? model[a] : 8'hFF;
  endfunction

  function automatic logic [7:0] sig_exp(logic [11:0] a);
    case (a)
      12'h000: return 8'h1E;
      12'h100: return 8'h61;
      12'h200: return 8'h06;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] lock_exp(logic [2:0] l);
    return {3'b000, l, 2'b00};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      wait_clk(HALF);
      rx[i] = miso;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic cmd(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                     input logic [7:0] d, output logic [7:0] r);
    logic [7:0] t;
    xfer(a, t); xfer(b, t); xfer(c, t); xfer(d, r);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    wait_clk(195000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] r, t, d0, d1;
    logic [11:0] a0, a1;
    logic [11:0] ra [6];
    int bad;
    void'($urandom(32'd1234));
    wait_clk(5);
    check("R10 reset miso", {7'd0, miso}, 8'h00);
    isp_active = 1'b1;
    wait_clk(70);

    cmd(8'h28, 8'h00, 8'h00, 8'h00, r);
    check("R2 sig before enable", r, 8'h00);
    cmd(8'hAC, 8'h53, 8'h00, 8'h00, r);
    check("R2 enable echo", r, 8'h69);

    cmd(8'hAC, 8'h80, 8'h00, 8'h00, r);
    cmd(8'h20, 8'h00, 8'h05, 8'h00, r);
    check("R4 read during erase", r, 8'h00);
    cmd(8'h24, 8'h00, 8'h00, 8'h00, r);
    check("R4 lock read during erase", r, 8'h00);
    wait_clk(ER_CYC + 200);
    for (int k = 0; k < 4; k++) begin
      a0 = 12'($urandom);
      cmd(8'h20, {4'h0, a0[11:8]}, a0[7:0], 8'h00, r);
      check("R4 erased reads FF", r, 8'hFF);
    end
    cmd(8'h24, 8'h00, 8'h00, 8'h00, r);
    check("R9 lock after erase", r, lock_exp(3'b000));

    a0 = 12'h4A7; d0 = 8'h3C;
    cmd(8'h40, {4'h0, a0[11:8]}, a0[7:0], d0, r);
    model[int'(a0)] = d0;
    cmd(8'h20, {4'h0, a0[11:8]}, a0[7:0], 8'h00, r);
    check("R5 poll inverted msb", r, d0 ^ 8'h80);
    cmd(8'h20, 8'h00, 8'h10, 8'h00, r);
    check("R5 other addr true while busy", r, 8'hFF);
    wait_clk(WR_CYC + 100);
    cmd(8'h20, {4'h0, a0[11:8]}, a0[7:0], 8'h00, r);
    check("R3 byte read after write", r, d0);

    a0 = 12'h123; d0 = 8'hA5; a1 = 12'h124; d1 = 8'h5A;
    cmd(8'h40, {4'h0, a0[11:8]}, a0[7:0], d0, r);
    model[int'(a0)] = d0;
    cmd(8'h40, {4'h0, a1[11:8]}, a1[7:0], d1, r);
    wait_clk(WR_CYC + 100);
    cmd(8'h20, {4'h0, a1[11:8]}, a1[7:0], 8'h00, r);
    check("R6 write while busy dropped", r, 8'hFF);
    cmd(8'h20, {4'h0, a0[11:8]}, a0[7:0], 8'h00, r);
    check("R3 first write kept", r, d0);

    for (int k = 0; k < 6; k++) begin
      ra[k] = {4'($urandom_range(4, 15)), 8'($urandom)};
      d0 = 8'($urandom);
      cmd(8'h40, {4'h0, ra[k][11:8]}, ra[k][7:0], d0, r);
      model[int'(ra[k])] = d0;
      wait_clk(WR_CYC + 50);
    end
    for (int k = 0; k < 6; k++) begin
      cmd(8'h20, {4'h0, ra[k][11:8]}, ra[k][7:0], 8'h00, r);
      check("R3 random readback", r, mexp(int'(ra[k])));
    end

    cmd(8'h28, 8'h00, 8'h00, 8'h00, r); check("R8 sig 000", r, sig_exp(12'h000));
    cmd(8'h28, 8'h01, 8'h00, 8'h00, r); check("R8 sig 100", r, sig_exp(12'h100));
    cmd(8'h28, 8'h02, 8'h00, 8'h00, r); check("R8 sig 200", r, sig_exp(12'h200));
    cmd(8'h28, 8'h03, 8'h00, 8'h00, r); check("R8 sig other", r, sig_exp(12'h300));

    cmd(8'hAC, 8'hE1, 8'h00, 8'h00, r);
    cmd(8'h24, 8'h00, 8'h00, 8'h00, r); check("R9 lock1", r, lock_exp(3'b001));
    cmd(8'hAC, 8'hE0, 8'h00, 8'h00, r);
    cmd(8'h24, 8'h00, 8'h00, 8'h00, r); check("R9 mode00 no change", r, lock_exp(3'b001));
    cmd(8'hAC, 8'hE3, 8'h00, 8'h00, r);
    cmd(8'h24, 8'h00, 8'h00, 8'h00, r); check("R9 lock3", r, lock_exp(3'b101));
    cmd(8'hAC, 8'hE2, 8'h00, 8'h00, r);
    cmd(8'h24, 8'h00, 8'h00, 8'h00, r); check("R9 lock2", r, lock_exp(3'b111));

    xfer(8'h50, t); xfer(8'h03, t);
    for (int k = 0; k < 256; k++) begin
      d0 = 8'($urandom);
      model[12'h300 + k] = d0;
      xfer(d0, t);
    end
    cmd(8'h20, 8'h03, 8'hFF, 8'h00, r);
    check("R7 page write then poll last", r, mexp(12'h3FF) ^ 8'h80);
    wait_clk(WR_CYC + 100);
    cmd(8'h20, 8'h03, 8'h00, 8'h00, r);
    check("R7 page write offset 0", r, mexp(12'h300));

    xfer(8'h30, t); xfer(8'h03, t);
    bad = 0;
    for (int k = 0; k < 256; k++) begin
      xfer(8'h00, r);
      if (r !== mexp(12'h300 + k)) begin
        bad++;
        if (bad == 1) $display("FAIL R7 page read offset %0d actual=%h expected=%h",
                                 k, r, mexp(12'h300 + k));
      end
    end
    n_chk++;
    if (bad != 0) n_fail++;
    cmd(8'h28, 8'h01, 8'h00, 8'h00, r);
    check("R7 new opcode after page", r, sig_exp(12'h100));

    xfer(8'h20, t); xfer(8'h01, t);
    wait_clk(3);
    isp_active = 1'b0;
    wait_clk(5);
    isp_active = 1'b1;
    wait_clk(70);
    cmd(8'h28, 8'h00, 8'h00, 8'h00, r);
    check("R10 enable cleared", r, 8'h00);
    cmd(8'hAC, 8'h53, 8'h00, 8'h00, r);
    check("R10 re-enable echo", r, 8'h69);
    cmd(8'h20, 8'h01, 8'h23, 8'h00, r);
    check("R10 memory kept", r, mexp(12'h123));

    finish_run();
  end
endmodule